// File: doc/BRIEF.md
# DRAM Chip-Select Window Decoder

This block decides which DRAM chip select answers a CPU physical address. It holds four windows. Each window has a base word and a size word, and software reaches them through a small 32-bit register port. Windows come in 16 MiB steps: the size word stores the window size minus one, as a mask over address bits 31:24. The base word holds address bits 31:24 and the four extended bits 35:32 that sit above a 32-bit address.

Every size word has an enable bit and a 3-bit chip-select number. The chip-select number need not equal the window index, so one window can drive any physical chip select. The lookup port is purely combinational. It takes a 36-bit address and returns a hit flag, the chip-select number of the matching window, and the address offset inside that window. When two windows cover the same address, the window with the lower index wins.

Top module: `csw_decoder`

## Requirements
- R1: Window n has its base word at byte offset 8*n and its size word at 8*n+4, and these words read back through the register port. In the base word, bits 31:24 are address bits 31:24 and bits 3:0 are address bits 35:32. In the size word, bits 31:24 are (size-1) bits 31:24, bits 4:2 are the chip-select number, and bit 0 is the enable. All other bits are not stored and read as zero.
- R2: After reset every base word and every size word reads zero, so every window starts disabled and no lookup hits.
- R3: A window whose size-word bit 0 is clear never matches, whatever its base and mask hold.
- R4: A window matches when address bits 35:32 equal base bits 3:0, and address bits 31:24 equal base bits 31:24 at every position where the size mask bit is zero.
- R5: On a hit, the chip-select output equals size-word bits 4:2 of the matching window.
- R6: When more than one window matches, the lowest-numbered window selects the chip-select and offset outputs.
- R7: On a miss, the hit output is 0, the chip-select output is 0 and the offset output is 0.
- R8: On a hit, the offset output is address bits 23:0, with bits 31:24 set to address bits 31:24 ANDed with the size mask of the matching window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset (bits 1:0 ignored) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| lk_addr | input | 36 | Physical address to decode |
| lk_hit | output | 1 | Address falls in an enabled window |
| lk_cs | output | 3 | Chip-select number of the selected window |
| lk_offset | output | 32 | Offset of the address inside the selected window |

## Verification
The hardest case to reach is an address that several windows match at once. At the ports it looks the same as a single hit, unless the competing windows carry different chip-select numbers and masks. The stimulus therefore first programs windows that do not overlap and sweeps all 4096 values of address bits 35:24. It then enables a wide window that covers the others, and later disables one of the narrow ones. The same sweep is repeated after each change, so lower-index priority and disabled-window masking show up as changes in the chip-select number and the offset.

// File: rtl/csw_pkg.sv
package csw_pkg;
   localparam int CSW_REG_W   = 32;
   localparam int CSW_GRAN_LSB = 24;
   localparam int CSW_PHYS_W  = 36;
   localparam int CSW_CS_W    = 3;
   localparam int CSW_MASK_W  = CSW_REG_W - CSW_GRAN_LSB;
   localparam int CSW_HI_W    = CSW_PHYS_W - CSW_REG_W;
   localparam logic [CSW_REG_W-1:0] CSW_BASE_KEEP = 32'hFF00_000F;
   localparam logic [CSW_REG_W-1:0] CSW_SIZE_KEEP = 32'hFF00_001D;

   typedef struct packed {
      logic                  en;
      logic [CSW_CS_W-1:0]   cs;
      logic [CSW_MASK_W-1:0] smask;
      logic [CSW_HI_W-1:0]   bhi;
      logic [CSW_MASK_W-1:0] blo;
   } csw_win_t;

   function automatic logic [CSW_REG_W-1:0] csw_base_word(input csw_win_t w);
      logic [CSW_REG_W-1:0] r;
      r = '0;
      r[CSW_REG_W-1:CSW_GRAN_LSB] = w.blo;
      r[CSW_HI_W-1:0] = w.bhi;
      return r;
   endfunction

   function automatic logic [CSW_REG_W-1:0] csw_size_word(input csw_win_t w);
      logic [CSW_REG_W-1:0] r;
      r = '0;
      r[CSW_REG_W-1:CSW_GRAN_LSB] = w.smask;
      r[CSW_CS_W+1:2] = w.cs;
      r[0] = w.en;
      return r;
   endfunction
endpackage

// File: rtl/csw_regfile.sv
module csw_regfile
   import csw_pkg::*;
#(
   parameter int NUM_WIN = 4,
   localparam int RADDR_W = $clog2(NUM_WIN) + 3,
   localparam int WIDX_W  = $clog2(NUM_WIN)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [RADDR_W-1:0]      addr,
   input  logic [CSW_REG_W-1:0]    wdata,
   output logic [CSW_REG_W-1:0]    rdata,
   output csw_win_t [NUM_WIN-1:0]  cfg
);
   csw_win_t [NUM_WIN-1:0] cfg_q;
   logic [WIDX_W-1:0]      widx;
   logic                   sel_size;
   logic                   in_range;

   assign widx     = addr[RADDR_W-1:3];
   assign sel_size = addr[2];
   assign in_range = (int'(widx) < NUM_WIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (we && in_range) begin
         if (sel_size) begin
            cfg_q[widx].smask <= wdata[CSW_REG_W-1:CSW_GRAN_LSB];
            cfg_q[widx].cs    <= wdata[CSW_CS_W+1:2];
            cfg_q[widx].en    <= wdata[0];
         end else begin
            cfg_q[widx].blo   <= wdata[CSW_REG_W-1:CSW_GRAN_LSB];
            cfg_q[widx].bhi   <= wdata[CSW_HI_W-1:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (in_range)
         rdata = sel_size ? csw_size_word(cfg_q[widx]) : csw_base_word(cfg_q[widx]);
   end

   assign cfg = cfg_q;

   // R1
   base_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !sel_size) |=> (csw_base_word(cfg_q[$past(widx)]) == ($past(wdata) & CSW_BASE_KEEP)));
   // R1
   size_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel_size) |=> (csw_size_word(cfg_q[$past(widx)]) == ($past(wdata) & CSW_SIZE_KEEP)));
endmodule

// File: rtl/csw_match.sv
module csw_match
   import csw_pkg::*;
(
   input  csw_win_t                win,
   input  logic [CSW_PHYS_W-1:0]   addr,
   output logic                    hit,
   output logic [CSW_REG_W-1:0]    offset
);
   logic [CSW_MASK_W-1:0] fix_bits;
   logic                  hi_eq;
   logic                  lo_eq;

   assign fix_bits = ~win.smask;
   assign hi_eq    = (addr[CSW_PHYS_W-1:CSW_REG_W] == win.bhi);
   assign lo_eq    = ((addr[CSW_REG_W-1:CSW_GRAN_LSB] & fix_bits) == (win.blo & fix_bits));
   assign hit      = win.en && hi_eq && lo_eq;
   assign offset   = {addr[CSW_REG_W-1:CSW_GRAN_LSB] & win.smask, addr[CSW_GRAN_LSB-1:0]};
endmodule

// File: rtl/csw_prio.sv
module csw_prio
   import csw_pkg::*;
#(
   parameter int NUM_WIN = 4,
   localparam int WIDX_W = $clog2(NUM_WIN)
) (
   input  logic [NUM_WIN-1:0]                 hit_vec,
   input  logic [NUM_WIN-1:0][CSW_CS_W-1:0]   cs_vec,
   input  logic [NUM_WIN-1:0][CSW_REG_W-1:0]  off_vec,
   output logic                               any_hit,
   output logic [WIDX_W-1:0]                  win_idx,
   output logic [CSW_CS_W-1:0]                cs,
   output logic [CSW_REG_W-1:0]               offset
);
   always_comb begin
      any_hit = 1'b0;
      win_idx = '0;
      cs      = '0;
      offset  = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            any_hit = 1'b1;
            win_idx = WIDX_W'(i);
            cs      = cs_vec[i];
            offset  = off_vec[i];
         end
      end
   end
endmodule

// File: rtl/csw_decoder.sv
module csw_decoder
   import csw_pkg::*;
#(
   parameter int NUM_WIN = 4,
   localparam int RADDR_W = $clog2(NUM_WIN) + 3,
   localparam int WIDX_W  = $clog2(NUM_WIN)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [RADDR_W-1:0]      cfg_addr,
   input  logic [CSW_REG_W-1:0]    cfg_wdata,
   output logic [CSW_REG_W-1:0]    cfg_rdata,
   input  logic [CSW_PHYS_W-1:0]   lk_addr,
   output logic                    lk_hit,
   output logic [CSW_CS_W-1:0]     lk_cs,
   output logic [CSW_REG_W-1:0]    lk_offset
);
   generate
      if (NUM_WIN < 2 || NUM_WIN > 8) begin : g_bad_cfg
         $error("csw_decoder: NUM_WIN must lie in 2..8");
      end
   endgenerate

   csw_win_t [NUM_WIN-1:0]                cfg;
   logic [NUM_WIN-1:0]                    hit_vec;
   logic [NUM_WIN-1:0]                    en_vec;
   logic [NUM_WIN-1:0][CSW_CS_W-1:0]      cs_vec;
   logic [NUM_WIN-1:0][CSW_REG_W-1:0]     off_vec;
   logic [WIDX_W-1:0]                     win_idx;
   logic [NUM_WIN-1:0]                    below_mask;

   csw_regfile #(.NUM_WIN(NUM_WIN)) regs_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .addr  (cfg_addr),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .cfg   (cfg)
   );

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      csw_match match_i (
         .win    (cfg[g]),
         .addr   (lk_addr),
         .hit    (hit_vec[g]),
         .offset (off_vec[g])
      );
      assign cs_vec[g] = cfg[g].cs;
      assign en_vec[g] = cfg[g].en;
   end

   csw_prio #(.NUM_WIN(NUM_WIN)) prio_i (
      .hit_vec (hit_vec),
      .cs_vec  (cs_vec),
      .off_vec (off_vec),
      .any_hit (lk_hit),
      .win_idx (win_idx),
      .cs      (lk_cs),
      .offset  (lk_offset)
   );

   assign below_mask = (NUM_WIN'(1) << win_idx) - NUM_WIN'(1);

   // R3
   dis_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec & ~en_vec) == '0);
   // R6
   low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (hit_vec[win_idx] && ((hit_vec & below_mask) == '0)));
   // R5
   cs_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_cs == cfg[win_idx].cs));
   // R7
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_cs == '0 && lk_offset == '0));
   // R8
   low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_offset[CSW_GRAN_LSB-1:0] == lk_addr[CSW_GRAN_LSB-1:0]));
   // R2
   rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (en_vec == '0));
endmodule

// File: tb/csw_decoder_tb.sv
module csw_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [35:0] lk_addr = '0;
   logic        lk_hit;
   logic [2:0]  lk_cs;
   logic [31:0] lk_offset;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   logic [7:0] m_blo [4];
   logic [3:0] m_bhi [4];
   logic [7:0] m_sm  [4];
   logic [2:0] m_cs  [4];
   bit         m_en  [4];

   always #2 clk = ~clk;

   csw_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_addr(lk_addr),
      .lk_hit(lk_hit), .lk_cs(lk_cs), .lk_offset(lk_offset)
   );

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc >= 200000 && !done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         summary();
         $finish;
      end
   end

   task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic reg_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
      cfg_addr = a;
      #1;
      n_chk++;
      if (cfg_rdata !== exp) begin
         n_bad++;
         $display("FAIL %s reg 0x%0h actual=%h expected=%h", tag, a, cfg_rdata, exp);
      end
   endtask

   task automatic set_win(input int i, input logic [7:0] blo, input logic [3:0] bhi,
                          input logic [7:0] sm, input logic [2:0] cs, input bit en);
      reg_wr(5'(i * 8), {blo, 20'h0, bhi});
      reg_wr(5'(i * 8 + 4), {sm, 19'h0, cs, 1'b0, en});
      m_blo[i] = blo; m_bhi[i] = bhi; m_sm[i] = sm; m_cs[i] = cs; m_en[i] = en;
   endtask

   task automatic sweep(input string tag);
      for (int k = 0; k < 4096; k++) begin
         logic [35:0] a;
         bit          eh;
         logic [2:0]  ec;
         logic [31:0] eo;
         a = {12'(k), 24'((k * 24'h9E3779) ^ 24'h5A5A5A)};
         eh = 1'b0; ec = '0; eo = '0;
         for (int i = 0; i < 4; i++) begin
            if (!eh && m_en[i] && a[35:32] == m_bhi[i] &&
                ((a[31:24] & ~m_sm[i]) == (m_blo[i] & ~m_sm[i]))) begin
               eh = 1'b1;
               ec = m_cs[i];
               eo = {a[31:24] & m_sm[i], a[23:0]};
            end
         end
         lk_addr = a;
         #1;
         n_chk++;
         if (lk_hit !== eh || lk_cs !== ec || lk_offset !== eo) begin
            n_bad++;
            $display("FAIL %s addr=%h actual hit=%0b cs=%0d off=%h expected hit=%0b cs=%0d off=%h",
                     tag, a, lk_hit, lk_cs, lk_offset, eh, ec, eo);
         end
      end
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin
         m_blo[i] = '0; m_bhi[i] = '0; m_sm[i] = '0; m_cs[i] = '0; m_en[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: all words zero after reset, nothing hits
      for (int r = 0; r < 8; r++) reg_chk("R2", 5'(r * 4), 32'h0);
      sweep("R2 R7 reset-miss");

      // R1: unstored bits read zero, offsets 8n / 8n+4
      for (int i = 0; i < 4; i++) begin
         reg_wr(5'(i * 8), 32'hFFFF_FFFF);
         reg_wr(5'(i * 8 + 4), 32'hFFFF_FFFF);
      end
      for (int i = 0; i < 4; i++) begin
         reg_chk("R1 base", 5'(i * 8), 32'hFF00_000F);
         reg_chk("R1 size", 5'(i * 8 + 4), 32'hFF00_001D);
      end
      reg_wr(5'd12, 32'h0000_0000);
      reg_chk("R1 size-clear", 5'd12, 32'h0);
      reg_chk("R1 neighbour", 5'd8, 32'hFF00_000F);

      // R4 R5 R8: disjoint windows, chip selects reordered, window 3 off (R3)
      set_win(0, 8'h00, 4'h0, 8'h0F, 3'd2, 1'b1);
      set_win(1, 8'h10, 4'h0, 8'h0F, 3'd5, 1'b1);
      set_win(2, 8'h18, 4'h1, 8'h07, 3'd7, 1'b1);
      set_win(3, 8'h00, 4'h0, 8'hFF, 3'd3, 1'b0);
      reg_chk("R1 cs-field", 5'd4, 32'h0F00_0009);
      sweep("R4 R5 R8 R3 disjoint");

      // R6: window 3 covers windows 0 and 1
      set_win(3, 8'h00, 4'h0, 8'hFF, 3'd3, 1'b1);
      sweep("R6 overlap");

      // R3: disabling window 0 lets window 3 take its range
      set_win(0, 8'h00, 4'h0, 8'h0F, 3'd2, 1'b0);
      sweep("R3 R6 disable-low");

      // R7: only a window in the extended region remains
      set_win(1, 8'h10, 4'h0, 8'h0F, 3'd5, 1'b0);
      set_win(3, 8'h00, 4'h0, 8'hFF, 3'd3, 1'b0);
      sweep("R7 R4 sparse");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule